// File: doc/BRIEF.md
# Monochrome hardware cursor overlay

This block lays a 64x64 two-plane cursor over the outgoing pixel stream of a 32-bit framebuffer display. Software programs a cursor base address, a packed X/Y position, a packed hotspot correction, two 24-bit colours and an enable. When a scanline starts, the block decides whether the line falls inside the cursor's vertical window. If it does, it reads that line's 16 bitmap bytes through a byte-wide memory read port while the display is still in horizontal blank.

During active video each pixel passes through one register stage. Pixels that fall under the cursor are changed according to an AND/XOR bit pair: the pixel can be replaced by either colour, left as it is, or inverted. Columns at or past the active display width are never touched, so the cursor never wraps onto the next line.

The cursor parameters used for display are a second copy of the programmed ones. The copy is refreshed only at frame start or during vertical blank, and never while the lock bit is set. Software can therefore update several registers without the display showing a partial change.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, `pix_o` is 0, `pix_valid_o` is 0, `mem_req_o` is 0 and the displayed cursor is disabled.
- R2: On `line_start_i` for a line L inside the window, the block issues exactly 16 byte reads on consecutive cycles. The first address is base - hoff - voff*16 + (L - Y)*16 and each further address is one higher.
- R3: No read is issued and no pixel is modified when the displayed enable (control register 5, bit 0) is clear, when L < Y or L > Y+63, or when L > `v_disp_i`.
- R4: A pixel whose AND bit is 0 becomes {8'hFF, colour1} when its XOR bit is 1 and {8'hFF, colour0} when its XOR bit is 0. The colour registers (3 = colour0, 4 = colour1) keep bits 23:0 only.
- R5: A pixel whose AND bit is 1 and XOR bit is 0 leaves the output equal to the input pixel.
- R6: A pixel whose AND bit is 1 and XOR bit is 1 becomes the bitwise complement of the input pixel.
- R7: Fetched bytes 0..7 of a line form the AND plane and bytes 8..15 form the XOR plane. Bit 7 of plane byte i covers cursor column 8*i and bit 0 covers column 8*i+7. The cursor column is `pix_x_i` - X.
- R8: A pixel with `pix_x_i` >= (`h_disp_i` + 1) * 8 is never modified.
- R9: Register 0 holds the base address in bits 30:0 and the lock in bit 31. While the lock is set, the displayed parameters do not change, though register writes still update the programmed values.
- R10: A write to the position register (1) or the hotspot register (2) copies its bit 31 into the lock. Clearing the lock this way lets the pending values take effect at the next transfer point.
- R11: Programmed values reach the display only at `frame_start_i` or while `vblank_i` is high, and only when the lock is clear.
- R12: `pix_o` and `pix_valid_o` follow `pix_i` and `pix_valid_i` with exactly one cycle of latency.
- R13: Register field positions: position X is in bits 29:16 and Y in bits 11:0. The hotspot horizontal offset is in bits 21:16 and the vertical offset in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select: 0 base/lock, 1 position, 2 hotspot, 3 colour0, 4 colour1, 5 control |
| reg_wdata_i | input | 32 | Register write data |
| h_disp_i | input | 11 | Active width in 8-pixel units, minus one |
| v_disp_i | input | LW | Last displayed line number |
| frame_start_i | input | 1 | Start-of-frame pulse |
| vblank_i | input | 1 | Vertical blank level |
| line_start_i | input | 1 | Pulse at the start of horizontal blank before a line |
| line_i | input | LW | Number of the line being prepared |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_x_i | input | XW | Column of the input pixel |
| pix_i | input | 32 | Input framebuffer pixel |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_o | output | 32 | Composited pixel |
| mem_req_o | output | 1 | Bitmap byte read request |
| mem_addr_o | output | AW | Bitmap byte address |
| mem_rdata_i | input | 8 | Read data, one cycle after the request |

## Verification
A wrong line address or a wrong plane order shows at once. The read addresses of the next cursor line would be off, and the first pixels under the cursor would take the wrong colour or fail to invert. A display copy that refreshes at the wrong time, or ignores the lock, only shows one line later, when the fetch address reveals a stale or premature base. The bench therefore checks fetch addresses around each lock, unlock and blank event. A broken clip or window test would modify pixels that should pass through unchanged, so the bench probes columns on both sides of each edge and lines on both sides of each vertical limit.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
  localparam int CUR_DIM     = 64;
  localparam int LINE_BYTES  = 16;
  localparam int PLANE_BYTES = LINE_BYTES / 2;

  typedef enum logic [2:0] {
    REG_BASE = 3'd0,
    REG_POS  = 3'd1,
    REG_HOT  = 3'd2,
    REG_CLR0 = 3'd3,
    REG_CLR1 = 3'd4,
    REG_CTRL = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic        en;
    logic [30:0] base;
    logic [13:0] x;
    logic [11:0] y;
    logic [5:0]  hoff;
    logic [5:0]  voff;
    logic [23:0] clr0;
    logic [23:0] clr1;
  } cur_cfg_t;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_ovl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        frame_start_i,
  input  logic        vblank_i,
  output cur_cfg_t    act_o,
  output logic        lock_o
);
  cur_cfg_t sh_q, act_q;
  logic     lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      lock_q <= 1'b0;
    end else if (we_i) begin
      unique case (reg_sel_e'(addr_i))
        REG_BASE: begin
          sh_q.base <= wdata_i[30:0];
          lock_q    <= wdata_i[31];
        end
        REG_POS: begin
          sh_q.x <= wdata_i[29:16];
          sh_q.y <= wdata_i[11:0];
          lock_q <= wdata_i[31];
        end
        REG_HOT: begin
          sh_q.hoff <= wdata_i[21:16];
          sh_q.voff <= wdata_i[5:0];
          lock_q    <= wdata_i[31];
        end
        REG_CLR0: sh_q.clr0 <= wdata_i[23:0];
        REG_CLR1: sh_q.clr1 <= wdata_i[23:0];
        REG_CTRL: sh_q.en   <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // display copy: frame start or vblank, never while locked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else if (!lock_q && (frame_start_i || vblank_i)) act_q <= sh_q;
  end

  assign act_o  = act_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/cursor_fetch.sv
module cursor_fetch
  import cursor_ovl_pkg::*;
#(
  parameter int AW = 24,
  parameter int LW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  cur_cfg_t             cfg_i,
  input  logic [LW-1:0]        v_disp_i,
  input  logic                 line_start_i,
  input  logic [LW-1:0]        line_i,
  output logic                 mem_req_o,
  output logic [AW-1:0]        mem_addr_o,
  input  logic [7:0]           mem_rdata_i,
  output logic [CUR_DIM-1:0]   and_bits_o,
  output logic [CUR_DIM-1:0]   xor_bits_o,
  output logic                 line_vld_o
);
  localparam int CW = $clog2(LINE_BYTES);

  logic [LW:0]     line_e, y_e, rel;
  logic            in_win;
  logic [31:0]     addr_calc;
  logic [AW-1:0]   line_addr_q;
  logic            busy_q, rd_vld_q, line_vld_q;
  logic [CW-1:0]   cnt_q, rd_idx_q;
  logic [7:0]      byte_q [LINE_BYTES];

  assign line_e = {1'b0, line_i};
  assign y_e    = (LW+1)'(cfg_i.y);
  assign rel    = line_e - y_e;
  assign in_win = cfg_i.en && (line_e >= y_e) && (rel < (LW+1)'(CUR_DIM)) &&
                  (line_i <= v_disp_i);

  assign addr_calc = {1'b0, cfg_i.base} - 32'(cfg_i.hoff) - (32'(cfg_i.voff) << 4)
                   + (32'(rel) << 4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      line_addr_q <= '0;
    end else if (line_start_i) begin
      busy_q      <= in_win;
      cnt_q       <= '0;
      line_addr_q <= AW'(addr_calc);
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(LINE_BYTES - 1)) busy_q <= 1'b0;
    end
  end

  assign mem_req_o  = busy_q;
  assign mem_addr_o = line_addr_q + AW'(cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q   <= 1'b0;
      rd_idx_q   <= '0;
      line_vld_q <= 1'b0;
    end else begin
      rd_vld_q <= busy_q && !line_start_i;
      rd_idx_q <= cnt_q;
      if (line_start_i) line_vld_q <= 1'b0;
      else if (rd_vld_q && rd_idx_q == CW'(LINE_BYTES - 1)) line_vld_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINE_BYTES; i++) byte_q[i] <= '0;
    end else if (rd_vld_q) begin
      byte_q[rd_idx_q] <= mem_rdata_i;
    end
  end

  // plane byte k, bit 7 -> column 8k (stored at vector bit 63-8k)
  for (genvar k = 0; k < PLANE_BYTES; k++) begin : g_plane
    assign and_bits_o[CUR_DIM-1-8*k -: 8] = byte_q[k];
    assign xor_bits_o[CUR_DIM-1-8*k -: 8] = byte_q[k+PLANE_BYTES];
  end

  assign line_vld_o = line_vld_q;
endmodule

// File: rtl/cursor_mix.sv
module cursor_mix
  import cursor_ovl_pkg::*;
#(
  parameter int XW = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_vld_i,
  input  logic [13:0]        cur_x_i,
  input  logic [23:0]        clr0_i,
  input  logic [23:0]        clr1_i,
  input  logic [10:0]        h_disp_i,
  input  logic [CUR_DIM-1:0] and_bits_i,
  input  logic [CUR_DIM-1:0] xor_bits_i,
  input  logic               pix_valid_i,
  input  logic [XW-1:0]      pix_x_i,
  input  logic [31:0]        pix_i,
  output logic               pix_valid_o,
  output logic [31:0]        pix_o
);
  localparam int EW = (XW > 15) ? XW + 1 : 16;

  logic [EW-1:0] x_e, cx_e, col_full, width;
  logic [5:0]    col, idx;
  logic          hit, a_bit, x_bit;
  logic [31:0]   mixed;

  assign x_e      = EW'(pix_x_i);
  assign cx_e     = EW'(cur_x_i);
  assign col_full = x_e - cx_e;
  assign width    = EW'({1'b0, h_disp_i} + 12'd1) << 3;
  assign hit      = line_vld_i && (x_e >= cx_e) && (col_full < EW'(CUR_DIM)) &&
                    (x_e < width);
  assign col      = col_full[5:0];
  assign idx      = 6'(CUR_DIM - 1) - col;
  assign a_bit    = and_bits_i[idx];
  assign x_bit    = xor_bits_i[idx];

  always_comb begin
    mixed = pix_i;
    if (hit) begin
      if (!a_bit)     mixed = {8'hFF, x_bit ? clr1_i : clr0_i};
      else if (x_bit) mixed = ~pix_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o <= 1'b0;
      pix_o       <= '0;
    end else begin
      pix_valid_o <= pix_valid_i;
      pix_o       <= mixed;
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_ovl_pkg::*;
#(
  parameter int AW = 24,
  parameter int XW = 16,
  parameter int LW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic [10:0]   h_disp_i,
  input  logic [LW-1:0] v_disp_i,
  input  logic          frame_start_i,
  input  logic          vblank_i,
  input  logic          line_start_i,
  input  logic [LW-1:0] line_i,
  input  logic          pix_valid_i,
  input  logic [XW-1:0] pix_x_i,
  input  logic [31:0]   pix_i,
  output logic          pix_valid_o,
  output logic [31:0]   pix_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rdata_i
);
  cur_cfg_t           act_cfg;
  logic               lock;
  logic               line_vld;
  logic [CUR_DIM-1:0] and_bits, xor_bits;

  cursor_regs u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (reg_we_i),
    .addr_i        (reg_addr_i),
    .wdata_i       (reg_wdata_i),
    .frame_start_i (frame_start_i),
    .vblank_i      (vblank_i),
    .act_o         (act_cfg),
    .lock_o        (lock)
  );

  cursor_fetch #(.AW(AW), .LW(LW)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (act_cfg),
    .v_disp_i     (v_disp_i),
    .line_start_i (line_start_i),
    .line_i       (line_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rdata_i  (mem_rdata_i),
    .and_bits_o   (and_bits),
    .xor_bits_o   (xor_bits),
    .line_vld_o   (line_vld)
  );

  cursor_mix #(.XW(XW)) u_mix (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_vld_i  (line_vld),
    .cur_x_i     (act_cfg.x),
    .clr0_i      (act_cfg.clr0),
    .clr1_i      (act_cfg.clr1),
    .h_disp_i    (h_disp_i),
    .and_bits_i  (and_bits),
    .xor_bits_i  (xor_bits),
    .pix_valid_i (pix_valid_i),
    .pix_x_i     (pix_x_i),
    .pix_i       (pix_i),
    .pix_valid_o (pix_valid_o),
    .pix_o       (pix_o)
  );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
  import cursor_ovl_pkg::*;
#(
  parameter int AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          line_start_i,
  input logic          mem_req_i,
  input logic [AW-1:0] mem_addr_i,
  input logic          pix_valid_i,
  input logic          pix_valid_o,
  input logic [31:0]   pix_i,
  input logic [31:0]   pix_o,
  input logic          line_vld_i,
  input logic          lock_i,
  input cur_cfg_t      act_cfg_i
);
  logic [5:0] req_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           req_cnt_q <= '0;
    else if (line_start_i) req_cnt_q <= '0;
    else if (mem_req_i)    req_cnt_q <= req_cnt_q + 1'b1;
  end

  // R2: no more than one line's worth of reads per line start
  p_req_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> req_cnt_q < 6'(LINE_BYTES));

  // R2: back-to-back reads walk consecutive addresses
  p_addr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && $past(mem_req_i) && !$past(line_start_i)) |->
      mem_addr_i == AW'($past(mem_addr_i) + 1'b1));

  // R12: valid follows with one cycle latency
  p_valid_lat_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pix_valid_o == $past(pix_valid_i));

  // R3: without a fetched line, pixels pass unchanged
  p_passthru_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_vld_i |=> pix_o == $past(pix_i));

  // R9: display copy frozen while locked
  p_lock_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(act_cfg_i));
endmodule

bind cursor_overlay cursor_overlay_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_start_i (line_start_i),
  .mem_req_i    (mem_req_o),
  .mem_addr_i   (mem_addr_o),
  .pix_valid_i  (pix_valid_i),
  .pix_valid_o  (pix_valid_o),
  .pix_i        (pix_i),
  .pix_o        (pix_o),
  .line_vld_i   (line_vld),
  .lock_i       (lock),
  .act_cfg_i    (act_cfg)
);

// File: tb/cursor_overlay_bench.sv
`timescale 1ns/1ps
module cursor_overlay_bench;
  localparam int AW = 24, XW = 16, LW = 12;

  logic          clk_i = 0, rst_ni = 0;
  logic          reg_we_i = 0;
  logic [2:0]    reg_addr_i = 0;
  logic [31:0]   reg_wdata_i = 0;
  logic [10:0]   h_disp_i = 11'd79;
  logic [LW-1:0] v_disp_i = 12'd479;
  logic          frame_start_i = 0, vblank_i = 0, line_start_i = 0;
  logic [LW-1:0] line_i = 0;
  logic          pix_valid_i = 0;
  logic [XW-1:0] pix_x_i = 0;
  logic [31:0]   pix_i = 0;
  logic          pix_valid_o;
  logic [31:0]   pix_o;
  logic          mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_rdata_i = 0;

  always #10 clk_i = ~clk_i;

  cursor_overlay #(.AW(AW), .XW(XW), .LW(LW)) u_cursor_overlay (.*);

  logic [7:0]    mem [0:2047];
  logic [AW-1:0] req_log [0:1023];
  int            req_total = 0;
  int            n_chk = 0, n_fail = 0;
  bit            done = 0;

  localparam logic [31:0] C0 = 32'hFF123456, C1 = 32'hFFABCDEF;

  always @(posedge clk_i) begin
    if (mem_req_o) begin
      mem_rdata_i <= mem[mem_addr_o[10:0]];
      req_log[req_total[9:0]] <= mem_addr_o;
      req_total <= req_total + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i); reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 0;
  endtask

  task automatic pulse_frame();
    @(negedge clk_i); frame_start_i = 1;
    @(negedge clk_i); frame_start_i = 0;
  endtask

  task automatic pulse_vblank();
    @(negedge clk_i); vblank_i = 1;
    @(negedge clk_i); vblank_i = 0;
  endtask

  // returns number of reads and first/last addresses for one line
  task automatic run_line(input int ln, output int cnt, output logic [AW-1:0] first, output logic [AW-1:0] last);
    int start;
    @(negedge clk_i); start = req_total; line_start_i = 1; line_i = LW'(ln);
    @(negedge clk_i); line_start_i = 0;
    repeat (22) @(negedge clk_i);
    cnt = req_total - start;
    first = (cnt > 0) ? req_log[start[9:0]] : '0;
    last  = (cnt > 0) ? req_log[(start + cnt - 1) & 1023] : '0;
  endtask

  task automatic pix(input int x, input logic [31:0] pin, input logic [31:0] exp, input string req);
    pix_valid_i = 1; pix_x_i = XW'(x); pix_i = pin;
    @(negedge clk_i);
    pix_valid_i = 0;
    chk(pix_o == exp, req, pix_o, exp);
  endtask

  task automatic expect_fetch(input int ln, input int exp_cnt, input logic [AW-1:0] exp_first, input string req);
    int c; logic [AW-1:0] f, l;
    run_line(ln, c, f, l);
    chk(c == exp_cnt, req, 32'(c), 32'(exp_cnt));
    if (exp_cnt > 0) begin
      chk(f == exp_first, req, 32'(f), 32'(exp_first));
      chk(l == exp_first + 15, req, 32'(l), 32'(exp_first + 15));
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(pix_o == 0 && pix_valid_o == 0, "R1 outputs", pix_o, 0);
    chk(mem_req_o == 0, "R1 req", 32'(mem_req_o), 0);
  endtask

  task automatic t_setup_and_transfer();
    wr(3'd0, 32'h0000_0200);
    wr(3'd1, (32'd100 << 16) | 32'd10);
    wr(3'd2, 32'h0);
    wr(3'd3, 32'hAB12_3456);
    wr(3'd4, 32'h00AB_CDEF);
    wr(3'd5, 32'h1);
    expect_fetch(12, 0, '0, "R11 no transfer before frame start");
    pulse_frame();
    expect_fetch(12, 16, 24'h220, "R2 line fetch");
  endtask

  task automatic t_pixels();
    pix(100, 32'h1122_3344, 32'hEEDD_CCBB, "R6 invert col0");
    pix(102, 32'h1122_3344, 32'h1122_3344, "R5 transparent col2");
    pix(104, 32'h5555_5555, C1, "R4 colour1 col4");
    pix(106, 32'h5555_5555, C0, "R4 colour0 col6");
    pix(108, 32'h0, C1, "R7 second AND byte col8");
    pix(116, 32'h7777_0000, 32'h7777_0000, "R7 byte2 transparent");
    pix(99, 32'h0BAD_0001, 32'h0BAD_0001, "R3 left of cursor");
    pix(164, 32'h0BAD_0002, 32'h0BAD_0002, "R3 right of cursor");
    // R12 latency: valid out mirrors valid in one cycle later
    pix_valid_i = 1; @(negedge clk_i);
    chk(pix_valid_o == 1, "R12 valid rise", 32'(pix_valid_o), 1);
    pix_valid_i = 0; @(negedge clk_i);
    chk(pix_valid_o == 0, "R12 valid fall", 32'(pix_valid_o), 0);
  endtask

  task automatic t_clip();
    pix(127, 32'h1, C0, "R8 inside width 640");
    h_disp_i = 11'd15;
    pix(127, 32'h1, C0, "R8 last column before edge");
    pix(128, 32'h2, 32'h2, "R8 clipped at edge");
    h_disp_i = 11'd79;
    pix(128, 32'h2, C0, "R8 unclipped when wider");
  endtask

  task automatic t_window();
    expect_fetch(9, 0, '0, "R3 above window");
    pix(104, 32'h9, 32'h9, "R3 no overlay above window");
    expect_fetch(73, 16, 24'h5F0, "R3 last cursor line");
    expect_fetch(74, 0, '0, "R3 below window");
    v_disp_i = 12'd11;
    expect_fetch(12, 0, '0, "R3 beyond vertical display");
    v_disp_i = 12'd479;
  endtask

  task automatic t_hotspot();
    wr(3'd2, (32'd3 << 16) | 32'd2);
    pulse_frame();
    expect_fetch(12, 16, 24'h1FD, "R13 hotspot correction");
    wr(3'd2, 32'h0);
    pulse_frame();
  endtask

  task automatic t_lock();
    wr(3'd0, 32'h8000_0400);
    pulse_frame();
    expect_fetch(12, 16, 24'h220, "R9 locked base held");
    wr(3'd1, (32'd100 << 16) | 32'd10);
    expect_fetch(12, 16, 24'h220, "R11 unlocked but no transfer point");
    pulse_vblank();
    expect_fetch(12, 16, 24'h420, "R10 unlock applied in vblank");
  endtask

  task automatic t_disable();
    wr(3'd5, 32'h0);
    pulse_frame();
    expect_fetch(12, 0, '0, "R3 disabled no fetch");
    pix(104, 32'h3, 32'h3, "R3 disabled no overlay");
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    // line 12 at 0x220: AND bytes 0..7, XOR bytes 8..15
    mem[11'h220] = 8'hF0; mem[11'h221] = 8'h00; mem[11'h222] = 8'hFF; mem[11'h223] = 8'h00;
    for (int i = 4; i < 8; i++) mem[11'h220 + i] = 8'hFF;
    mem[11'h228] = 8'hCC; mem[11'h229] = 8'hFF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_setup_and_transfer();
    t_pixels();
    t_clip();
    t_window();
    t_hotspot();
    t_lock();
    t_disable();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule